// File: doc/BRIEF.md
# Register Access Command Executor

This block sits between a command word queue and an on-chip register bus. It pulls 32-bit words from the queue one at a time, and for each command it runs one or more accesses on a request/acknowledge register bus with a 24-bit address and a 32-bit data path. Result words go out on a one-cycle push strobe to a downstream response builder, which is assumed to accept every push. Frame parsing and frame assembly are done by neighbouring blocks.

There are two command families. A single command carries one of six operations: plain read, plain write, polling until the masked bits are all clear or all set, and read-modify-write that clears or sets the masked bits. A burst command moves a counted run of words in one direction, starting at a given address and stepping by four bytes per access. A polling command gives up after a parameterised number of reads and reports a fixed error word instead of data.

Top module: `regcmd_exec`

## Requirements
- R1: During reset and in the first cycle after it, `bus_req` and `rsp_valid` are low, and `cmd_ready` is high because the block is waiting for a header word.
- R2: A header word selects the command family from bits [15:0]: 0x0001 starts a single command, 0x0002 starts a burst. A header with any other value is discarded on its own, and the next word is again read as a header.
- R3: A single command is the header, then a command word (opcode in bits [31:29], byte enables in bits [27:24], address in bits [23:0]), then an operand word. Opcode 001 (read) runs one read with all four byte enables set and pushes the read data.
- R4: Opcode 010 (write) runs one write of the operand word, using the command's byte enables and address. It pushes no response.
- R5: Opcode 011 (poll until clear) and 100 (poll until set) read the register again and again until every bit selected by the operand mask is 0 (or 1). The last value read is then pushed.
- R6: If a poll finds no match within WAIT_LIMIT reads, it stops reading and pushes ERR_WORD (default 0xDEADBEEF) in place of data.
- R7: Opcode 101 (clear bits) and 110 (set bits) read the register, then write (value & ~mask) or (value | mask) with the command's byte enables. The full written word is pushed.
- R8: Opcodes 000 and 111 take in their three words and cause no bus access and no response.
- R9: A burst command is the header followed by one word with the direction in bits [31:30] (01 read, 10 write), the count in bits [29:24] and the start address in bits [23:0]. Access k uses the start address plus 4·k, and every burst access has all byte enables set.
- R10: A burst read pushes one response per access, in address order. A burst write takes in exactly `count` data words after the burst word, writes them in order, and pushes nothing.
- R11: A burst with count 0, or with direction 00 or 11, makes no access and takes in no further words.
- R12: Once `bus_req` is raised, it stays high with address, direction, write data and byte enables unchanged until `bus_ack` is seen. No command word is taken while an access is open.
- R13: Every response is pushed in the cycle right after the acknowledge that produced it, with `rsp_valid` high for exactly one cycle per word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command queue holds a word |
| cmd_word | input | 32 | Word at the head of the command queue |
| cmd_ready | output | 1 | Word is taken when valid and ready are both high |
| bus_req | output | 1 | Register access request, held until acknowledged |
| bus_wr | output | 1 | 1 for a write, 0 for a read |
| bus_addr | output | 24 | Register byte address |
| bus_wdata | output | 32 | Write data |
| bus_be | output | 4 | Byte enables |
| bus_ack | input | 1 | Access completes in the cycle this is high with the request |
| bus_rdata | input | 32 | Read data, valid with the acknowledge |
| rsp_valid | output | 1 | One-cycle push of a response word |
| rsp_word | output | 32 | Response word |

## Verification
The bench runs every opcode against a behavioural register model. That model includes a status location whose low bit sets only after a few reads, so a poll that loops, a poll that hits on the first read, and a poll that times out each give a different read count and a different pushed word. Partial byte enables on writes and on modify write-backs, together with read-back, separate byte-masked merging from full-word writes. Bursts of 5 and of the maximum count 63, plus zero-count and bad-direction headers that are each followed at once by a plain read, show whether the block takes in the right number of words. The second half of the run varies the acknowledge latency so that request holding and response timing are tested with wait states.

// File: rtl/regcmd_pkg.sv
// Package: shared encodings for the register access command executor.
// Assumes 32-bit command words and a 24-bit register byte address.
package regcmd_pkg;

    localparam int WORD_W = 32;
    localparam int RADDR_W = 24;
    localparam int BE_W = WORD_W / 8;
    localparam int CNT_FLD_W = 6;

    localparam logic [15:0] CODE_SINGLE = 16'h0001;
    localparam logic [15:0] CODE_BURST  = 16'h0002;

    // Opcode positions inside the single command word
    localparam int OP_HI = 31;
    localparam int OP_LO = 29;
    localparam int BE_HI = 27;
    localparam int BE_LO = 24;

    typedef enum logic [2:0] {
        OP_NONE  = 3'b000,
        OP_READ  = 3'b001,
        OP_WRITE = 3'b010,
        OP_POLL0 = 3'b011,
        OP_POLL1 = 3'b100,
        OP_CLR   = 3'b101,
        OP_SET   = 3'b110,
        OP_RSVD  = 3'b111
    } op_e;

    typedef enum logic [1:0] {
        DIR_NONE  = 2'b00,
        DIR_READ  = 2'b01,
        DIR_WRITE = 2'b10,
        DIR_BAD   = 2'b11
    } dir_e;

    typedef struct packed {
        dir_e                   dir;
        logic [CNT_FLD_W-1:0]   count;
        logic [RADDR_W-1:0]     addr;
    } burst_t;

    typedef enum logic [3:0] {
        S_HDR,
        S_SCMD,
        S_SOPND,
        S_BHDR,
        S_BDATA,
        S_ACC,
        S_ACK,
        S_MWR,
        S_MACK
    } state_e;

    // True for opcodes that lead to bus activity
    function automatic logic op_known(op_e op);
        return (op != OP_NONE) && (op != OP_RSVD);
    endfunction

    function automatic logic op_is_poll(op_e op);
        return (op == OP_POLL0) || (op == OP_POLL1);
    endfunction

    function automatic logic op_is_mod(op_e op);
        return (op == OP_CLR) || (op == OP_SET);
    endfunction

endpackage

// File: rtl/regcmd_bus_port.sv
// Module: request/acknowledge register bus master port.
// On start it latches one access and holds the request steady until the
// target acknowledges. Assumes start is never pulsed while a request is open.
module regcmd_bus_port #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    localparam int BEN_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_wr,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] start_wdata,
    input  logic [BEN_W-1:0]  start_be,
    output logic              req,
    output logic              wr,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic [BEN_W-1:0]  be,
    input  logic              ack,
    output logic              done
);

    logic              req_q;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [BEN_W-1:0]  be_q;

    // Open a request on start, close it on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else if (start) begin
            req_q <= 1'b1;
        end else if (req_q && ack) begin
            req_q <= 1'b0;
        end
    end

    // Capture the access fields once per request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (start) begin
            wr_q    <= start_wr;
            addr_q  <= start_addr;
            wdata_q <= start_wdata;
            be_q    <= start_be;
        end
    end

    assign req   = req_q;
    assign wr    = wr_q;
    assign addr  = addr_q;
    assign wdata = wdata_q;
    assign be    = be_q;
    assign done  = req_q && ack;

endmodule

// File: rtl/regcmd_poll_timer.sv
// Module: counts failed poll reads and flags the last allowed one.
// clear restarts the count; tick marks one read that did not match.
// Assumes LIMIT is at least 1 and fits in CNT_W bits.
module regcmd_poll_timer #(
    parameter int LIMIT = 1000,
    parameter int CNT_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic last
);

    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count mismatching reads since the poll began
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == LAST_VAL);

endmodule

// File: rtl/regcmd_bit_eval.sv
// Module: evaluates a read value against a mask for poll and modify commands.
// Purely combinational; the opcode picks the target level of the masked bits.
module regcmd_bit_eval #(
    parameter int DATA_W = 32
) (
    input  regcmd_pkg::op_e    op,
    input  logic [DATA_W-1:0]  value,
    input  logic [DATA_W-1:0]  mask,
    output logic               match,
    output logic [DATA_W-1:0]  new_value
);
    import regcmd_pkg::*;

    logic [DATA_W-1:0] target;

    // Compare the masked bits with all-zero or all-one
    always_comb begin
        target = (op == OP_POLL1) ? mask : '0;
        match  = ((value & mask) == target);
    end

    // Form the write-back word of a modify command
    always_comb begin
        if (op == OP_CLR) begin
            new_value = value & ~mask;
        end else begin
            new_value = value | mask;
        end
    end

endmodule

// File: rtl/regcmd_exec.sv
// Module: register access command executor (top).
// Reads command words from a queue, runs single, poll, modify and burst
// accesses on a request/acknowledge register bus, and pushes result words.
// Assumes the response consumer always accepts a push, and that the queue
// holds its head word steady while cmd_valid is high and cmd_ready low.
module regcmd_exec #(
    parameter int          WAIT_LIMIT = 1000,
    parameter int          TMR_W      = 16,
    parameter int          ADDR_STEP  = 4,
    parameter logic [31:0] ERR_WORD   = 32'hDEAD_BEEF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [31:0] cmd_word,
    output logic        cmd_ready,
    output logic        bus_req,
    output logic        bus_wr,
    output logic [23:0] bus_addr,
    output logic [31:0] bus_wdata,
    output logic [3:0]  bus_be,
    input  logic        bus_ack,
    input  logic [31:0] bus_rdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_word
);
    import regcmd_pkg::*;

    localparam logic [BE_W-1:0] BE_ALL = '1;

    state_e               state_q;
    op_e                  op_q;
    logic [BE_W-1:0]      be_q;
    logic [RADDR_W-1:0]   addr_q;
    logic [WORD_W-1:0]    opnd_q;
    logic [WORD_W-1:0]    wval_q;
    logic                 burst_q;
    logic                 bwrite_q;
    logic [CNT_FLD_W-1:0] remain_q;
    logic                 rsp_valid_q;
    logic [WORD_W-1:0]    rsp_word_q;

    logic                 take;
    burst_t               bst_w;
    logic                 bst_ok;
    op_e                  op_w;
    logic                 acc_start;
    logic                 acc_wr;
    logic [WORD_W-1:0]    acc_wdata;
    logic [BE_W-1:0]      acc_be;
    logic                 acc_done;
    logic                 poll_last;
    logic                 poll_match;
    logic [WORD_W-1:0]    mod_value;
    logic                 poll_clear;
    logic                 poll_tick;

    // Word intake: only the fetch states accept from the queue
    always_comb begin
        cmd_ready = (state_q == S_HDR)   || (state_q == S_SCMD) ||
                    (state_q == S_SOPND) || (state_q == S_BHDR) ||
                    (state_q == S_BDATA);
        take      = cmd_ready && cmd_valid;
        bst_w     = burst_t'(cmd_word);
        bst_ok    = (bst_w.count != '0) &&
                    ((bst_w.dir == DIR_READ) || (bst_w.dir == DIR_WRITE));
        op_w      = op_e'(cmd_word[OP_HI:OP_LO]);
    end

    // Access launch: fields for the bus port in the two start states
    always_comb begin
        acc_start = (state_q == S_ACC) || (state_q == S_MWR);
        if (state_q == S_MWR) begin
            acc_wr = 1'b1;
        end else if (burst_q) begin
            acc_wr = bwrite_q;
        end else begin
            acc_wr = (op_q == OP_WRITE);
        end
        acc_wdata = (state_q == S_MWR) ? wval_q : opnd_q;
        acc_be    = (acc_wr && !burst_q) ? be_q : BE_ALL;
    end

    // Poll timer control: restart per command, advance per failed read
    always_comb begin
        poll_clear = (state_q == S_SOPND);
        poll_tick  = (state_q == S_ACK) && acc_done && !burst_q &&
                     op_is_poll(op_q) && !poll_match;
    end

    regcmd_bus_port #(
        .ADDR_W (RADDR_W),
        .DATA_W (WORD_W)
    ) u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (acc_start),
        .start_wr    (acc_wr),
        .start_addr  (addr_q),
        .start_wdata (acc_wdata),
        .start_be    (acc_be),
        .req         (bus_req),
        .wr          (bus_wr),
        .addr        (bus_addr),
        .wdata       (bus_wdata),
        .be          (bus_be),
        .ack         (bus_ack),
        .done        (acc_done)
    );

    regcmd_poll_timer #(
        .LIMIT (WAIT_LIMIT),
        .CNT_W (TMR_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (poll_clear),
        .tick  (poll_tick),
        .last  (poll_last)
    );

    regcmd_bit_eval #(
        .DATA_W (WORD_W)
    ) u_eval (
        .op        (op_q),
        .value     (bus_rdata),
        .mask      (opnd_q),
        .match     (poll_match),
        .new_value (mod_value)
    );

    // Command sequencer: fetch words, step through accesses, push results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= S_HDR;
            op_q        <= OP_NONE;
            be_q        <= '0;
            addr_q      <= '0;
            opnd_q      <= '0;
            wval_q      <= '0;
            burst_q     <= 1'b0;
            bwrite_q    <= 1'b0;
            remain_q    <= '0;
            rsp_valid_q <= 1'b0;
            rsp_word_q  <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            case (state_q)
                S_HDR: begin
                    if (take) begin
                        if (cmd_word[15:0] == CODE_SINGLE) begin
                            state_q <= S_SCMD;
                        end else if (cmd_word[15:0] == CODE_BURST) begin
                            state_q <= S_BHDR;
                        end
                    end
                end
                S_SCMD: begin
                    if (take) begin
                        op_q    <= op_w;
                        be_q    <= cmd_word[BE_HI:BE_LO];
                        addr_q  <= cmd_word[RADDR_W-1:0];
                        burst_q <= 1'b0;
                        state_q <= S_SOPND;
                    end
                end
                S_SOPND: begin
                    if (take) begin
                        opnd_q  <= cmd_word;
                        state_q <= op_known(op_q) ? S_ACC : S_HDR;
                    end
                end
                S_BHDR: begin
                    if (take) begin
                        burst_q  <= 1'b1;
                        bwrite_q <= (bst_w.dir == DIR_WRITE);
                        addr_q   <= bst_w.addr;
                        remain_q <= bst_w.count;
                        if (!bst_ok) begin
                            state_q <= S_HDR;
                        end else if (bst_w.dir == DIR_WRITE) begin
                            state_q <= S_BDATA;
                        end else begin
                            state_q <= S_ACC;
                        end
                    end
                end
                S_BDATA: begin
                    if (take) begin
                        opnd_q  <= cmd_word;
                        state_q <= S_ACC;
                    end
                end
                S_ACC: begin
                    state_q <= S_ACK;
                end
                S_ACK: begin
                    if (acc_done) begin
                        if (burst_q) begin
                            if (!bwrite_q) begin
                                rsp_valid_q <= 1'b1;
                                rsp_word_q  <= bus_rdata;
                            end
                            addr_q   <= addr_q + RADDR_W'(ADDR_STEP);
                            remain_q <= remain_q - 1'b1;
                            if (remain_q == CNT_FLD_W'(1)) begin
                                state_q <= S_HDR;
                            end else if (bwrite_q) begin
                                state_q <= S_BDATA;
                            end else begin
                                state_q <= S_ACC;
                            end
                        end else if (op_q == OP_READ) begin
                            rsp_valid_q <= 1'b1;
                            rsp_word_q  <= bus_rdata;
                            state_q     <= S_HDR;
                        end else if (op_is_poll(op_q)) begin
                            if (poll_match) begin
                                rsp_valid_q <= 1'b1;
                                rsp_word_q  <= bus_rdata;
                                state_q     <= S_HDR;
                            end else if (poll_last) begin
                                rsp_valid_q <= 1'b1;
                                rsp_word_q  <= ERR_WORD;
                                state_q     <= S_HDR;
                            end else begin
                                state_q <= S_ACC;
                            end
                        end else if (op_is_mod(op_q)) begin
                            wval_q  <= mod_value;
                            state_q <= S_MWR;
                        end else begin
                            state_q <= S_HDR;
                        end
                    end
                end
                S_MWR: begin
                    state_q <= S_MACK;
                end
                S_MACK: begin
                    if (acc_done) begin
                        rsp_valid_q <= 1'b1;
                        rsp_word_q  <= wval_q;
                        state_q     <= S_HDR;
                    end
                end
                default: begin
                    state_q <= S_HDR;
                end
            endcase
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_word  = rsp_word_q;

endmodule

// File: rtl/regcmd_exec_chk.sv
// Checker: temporal properties of the executor's bus and push interfaces.
// Attached to every instance of the top module by the bind below.
module regcmd_exec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_ready,
    input logic        bus_req,
    input logic        bus_wr,
    input logic [23:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic [3:0]  bus_be,
    input logic        bus_ack,
    input logic        rsp_valid
);

    // R1: leaving reset, no request and no push are active
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!bus_req && !rsp_valid));

    // R12: an unacknowledged request keeps all its fields
    a_r12_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_wr) &&
                                   $stable(bus_wdata) && $stable(bus_be)));

    // R12: no word is taken from the queue while an access is open
    a_r12_no_fetch_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !cmd_ready);

    // R13: every push follows an acknowledged access by one cycle
    a_r13_push_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(bus_req && bus_ack));

    // R13: a push lasts one cycle
    a_r13_single_cycle_push: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

bind regcmd_exec regcmd_exec_chk u_regcmd_exec_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_ready (cmd_ready),
    .bus_req   (bus_req),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_be    (bus_be),
    .bus_ack   (bus_ack),
    .rsp_valid (rsp_valid)
);

// File: tb/regcmd_exec_bench.sv
// Bench: behavioural register model and expectation queues, compared each clock.
module regcmd_exec_bench;

    localparam int          LIMIT = 8;
    localparam logic [31:0] ERR   = 32'hDEAD_BEEF;
    localparam logic [23:0] STAT  = 24'h000100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_word = '0;
    logic        cmd_ready;
    logic        bus_req;
    logic        bus_wr;
    logic [23:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [3:0]  bus_be;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_word;

    always #10 clk = ~clk;

    regcmd_exec #(
        .WAIT_LIMIT (LIMIT),
        .ERR_WORD   (ERR)
    ) u_regcmd_exec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .cmd_ready (cmd_ready),
        .bus_req   (bus_req),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_be    (bus_be),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .rsp_valid (rsp_valid),
        .rsp_word  (rsp_word)
    );

    int checks = 0;
    int fails = 0;
    int cycle = 0;
    bit finished = 0;

    logic [31:0] cmd_q[$];
    logic [60:0] acc_q[$];
    string       acc_tag[$];
    logic [31:0] rsp_q[$];
    string       rsp_tag[$];
    logic [31:0] mem[int];
    logic [31:0] shadow[int];
    int          stat_reads = 0;
    bit          lat_mode = 0;
    int          acc_seen = 0;
    int          last_ack_cycle = -10;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] init_val(input logic [23:0] a);
        return 32'hC3A5_0000 ^ {a[7:0], a};
    endfunction

    function automatic logic [31:0] bemask(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic logic [31:0] shadow_rd(input logic [23:0] a);
        if (shadow.exists(int'(a))) return shadow[int'(a)];
        return init_val(a);
    endfunction

    // Cycle counter
    initial forever begin
        @(posedge clk);
        cycle++;
    end

    // Command feeder, bus responder and response monitor, all at the falling edge
    initial begin
        bit offered = 0;
        bit seen = 0;
        int wait_n = 0;
        logic [23:0] f_addr = '0;
        logic        f_wr = 0;
        logic [31:0] f_wdata = '0;
        logic [3:0]  f_be = '0;
        forever begin
            @(negedge clk);
            // response check against the expectation queue (R13 timing)
            if (rsp_valid) begin
                if (rsp_q.size() == 0) begin
                    chk(0, "R8", "unexpected response", rsp_word, 32'h0);
                end else begin
                    chk(rsp_word == rsp_q[0], rsp_tag[0], "response word", rsp_word, rsp_q[0]);
                    void'(rsp_q.pop_front());
                    void'(rsp_tag.pop_front());
                end
                chk(cycle == last_ack_cycle + 1, "R13", "push one cycle after ack",
                    32'(cycle), 32'(last_ack_cycle + 1));
            end
            // command feeder
            if (offered) void'(cmd_q.pop_front());
            if (cmd_q.size() > 0) begin
                cmd_valid = 1'b1;
                cmd_word  = cmd_q[0];
            end else begin
                cmd_valid = 1'b0;
            end
            offered = cmd_valid && (cmd_ready === 1'b1);
            // bus responder
            if (bus_ack) begin
                bus_ack = 1'b0;
                seen = 0;
            end else if (bus_req === 1'b1) begin
                if (!seen) begin
                    seen = 1;
                    wait_n = lat_mode ? (acc_seen % 3) : 0;
                    acc_seen++;
                    f_addr = bus_addr; f_wr = bus_wr; f_wdata = bus_wdata; f_be = bus_be;
                end else begin
                    chk((f_addr == bus_addr) && (f_wr == bus_wr) && (f_wdata == bus_wdata) &&
                        (f_be == bus_be), "R12", "request fields held", {8'h0, bus_addr},
                        {8'h0, f_addr});
                end
                if (wait_n == 0) begin
                    bus_ack = 1'b1;
                    last_ack_cycle = cycle;
                    if (acc_q.size() == 0) begin
                        chk(0, "R8", "unexpected access", {8'h0, bus_addr}, 32'h0);
                    end else begin
                        chk({bus_wr, bus_be, bus_addr} == acc_q[0][60:32], acc_tag[0],
                            "access wr/be/addr", {3'b0, bus_wr, bus_be, bus_addr},
                            {3'b0, acc_q[0][60:32]});
                        if (bus_wr)
                            chk(bus_wdata == acc_q[0][31:0], acc_tag[0], "write data",
                                bus_wdata, acc_q[0][31:0]);
                        void'(acc_q.pop_front());
                        void'(acc_tag.pop_front());
                    end
                    if (bus_wr) begin
                        logic [31:0] old;
                        old = mem.exists(int'(bus_addr)) ? mem[int'(bus_addr)] : init_val(bus_addr);
                        mem[int'(bus_addr)] = (old & ~bemask(bus_be)) | (bus_wdata & bemask(bus_be));
                    end else if (bus_addr == STAT) begin
                        bus_rdata = (stat_reads >= 3) ? 32'h0000_0011 : 32'h0000_0010;
                        stat_reads++;
                    end else begin
                        bus_rdata = mem.exists(int'(bus_addr)) ? mem[int'(bus_addr)] : init_val(bus_addr);
                    end
                end else begin
                    wait_n--;
                end
            end
        end
    end

    task automatic exp_acc(input bit wr, input logic [3:0] be, input logic [23:0] a,
                           input logic [31:0] d, input string tag);
        acc_q.push_back({wr, be, a, d});
        acc_tag.push_back(tag);
        if (wr) shadow[int'(a)] = (shadow_rd(a) & ~bemask(be)) | (d & bemask(be));
    endtask

    task automatic exp_rsp(input logic [31:0] d, input string tag);
        rsp_q.push_back(d);
        rsp_tag.push_back(tag);
    endtask

    task automatic send_single(input logic [2:0] op, input logic [3:0] be,
                               input logic [23:0] a, input logic [31:0] opnd);
        cmd_q.push_back(32'h0000_0001);
        cmd_q.push_back({op, 1'b0, be, a});
        cmd_q.push_back(opnd);
    endtask

    task automatic send_burst(input logic [1:0] dir, input logic [5:0] n, input logic [23:0] a);
        cmd_q.push_back(32'h0000_0002);
        cmd_q.push_back({dir, n, a});
    endtask

    task automatic do_read(input logic [23:0] a, input string tag);
        exp_acc(0, 4'hF, a, 32'h0, tag);
        exp_rsp(shadow_rd(a), tag);
        send_single(3'b001, 4'hF, a, 32'h0);
    endtask

    task automatic do_write(input logic [23:0] a, input logic [31:0] d, input logic [3:0] be);
        exp_acc(1, be, a, d, "R4");
        send_single(3'b010, be, a, d);
    endtask

    task automatic do_modify(input bit set, input logic [3:0] be, input logic [23:0] a,
                             input logic [31:0] m);
        logic [31:0] nv;
        nv = set ? (shadow_rd(a) | m) : (shadow_rd(a) & ~m);
        exp_acc(0, 4'hF, a, 32'h0, "R7");
        exp_acc(1, be, a, nv, "R7");
        exp_rsp(nv, "R7");
        send_single(set ? 3'b110 : 3'b101, be, a, m);
    endtask

    task automatic drain(input string tag);
        int t = 0;
        while ((cmd_q.size() != 0 || acc_q.size() != 0 || rsp_q.size() != 0) && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (12) @(negedge clk);
        chk(acc_q.size() == 0, tag, "accesses left over", 32'(acc_q.size()), 32'h0);
        chk(rsp_q.size() == 0, tag, "responses left over", 32'(rsp_q.size()), 32'h0);
    endtask

    task automatic run_all();
        // R3 / R4: plain reads and writes, including partial byte enables
        do_read(24'h000010, "R3");
        do_write(24'h000020, 32'h1122_3344, 4'hF);
        do_write(24'h000024, 32'hAABB_CCDD, 4'b0101);
        do_read(24'h000020, "R3");
        do_read(24'h000024, "R4");
        drain("R4");
        // R2: unknown header code is dropped alone
        cmd_q.push_back(32'h0000_0005);
        do_read(24'h000030, "R2");
        drain("R2");
        // R8: reserved opcodes take three words and do nothing
        send_single(3'b000, 4'hF, 24'h000040, 32'h0000_0001);
        send_single(3'b111, 4'hF, 24'h000044, 32'h0000_0002);
        do_read(24'h000048, "R8");
        drain("R8");
        // R5: poll for set bit that appears on the fourth read
        stat_reads = 0;
        for (int i = 0; i < 4; i++) exp_acc(0, 4'hF, STAT, 32'h0, "R5");
        exp_rsp(32'h0000_0011, "R5");
        send_single(3'b100, 4'hF, STAT, 32'h0000_0001);
        drain("R5");
        // R5: poll for clear bit that is already clear
        do_write(24'h000050, 32'h0F0F_0F0F, 4'hF);
        exp_acc(0, 4'hF, 24'h000050, 32'h0, "R5");
        exp_rsp(32'h0F0F_0F0F, "R5");
        send_single(3'b011, 4'hF, 24'h000050, 32'h0000_0010);
        drain("R5");
        // R6: poll that never matches gives exactly LIMIT reads and the error word
        for (int i = 0; i < LIMIT; i++) exp_acc(0, 4'hF, STAT, 32'h0, "R6");
        exp_rsp(ERR, "R6");
        send_single(3'b011, 4'hF, STAT, 32'h0000_0010);
        drain("R6");
        // R7: set and clear masked bits, with a partial write-back
        do_modify(1, 4'hF, 24'h000080, 32'hF000_0001);
        do_modify(0, 4'b0011, 24'h000084, 32'h0000_FFFF);
        do_read(24'h000084, "R7");
        drain("R7");
        // R9 / R10: burst write of five words, then burst read back
        send_burst(2'b10, 6'd5, 24'h000200);
        for (int i = 0; i < 5; i++) begin
            exp_acc(1, 4'hF, 24'h000200 + 24'(4 * i), 32'h5000_0000 + 32'(i), "R9");
            cmd_q.push_back(32'h5000_0000 + 32'(i));
        end
        for (int i = 0; i < 5; i++) begin
            exp_acc(0, 4'hF, 24'h000200 + 24'(4 * i), 32'h0, "R10");
            exp_rsp(32'h5000_0000 + 32'(i), "R10");
        end
        send_burst(2'b01, 6'd5, 24'h000200);
        drain("R10");
        // R9: maximum count burst read
        for (int i = 0; i < 63; i++) begin
            exp_acc(0, 4'hF, 24'h001000 + 24'(4 * i), 32'h0, "R9");
            exp_rsp(shadow_rd(24'h001000 + 24'(4 * i)), "R9");
        end
        send_burst(2'b01, 6'd63, 24'h001000);
        drain("R9");
        // R11: zero count and bad directions take no further words
        send_burst(2'b10, 6'd0, 24'h000300);
        do_read(24'h000304, "R11");
        send_burst(2'b11, 6'd3, 24'h000310);
        do_read(24'h000314, "R11");
        send_burst(2'b00, 6'd2, 24'h000320);
        do_read(24'h000324, "R11");
        drain("R11");
    endtask

    // Main sequence
    initial begin
        repeat (4) @(negedge clk);
        chk(bus_req == 1'b0, "R1", "bus_req in reset", 32'(bus_req), 32'h0);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", 32'(rsp_valid), 32'h0);
        chk(cmd_ready == 1'b1, "R1", "cmd_ready in reset", 32'(cmd_ready), 32'h1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_req == 1'b0 && rsp_valid == 1'b0, "R1", "idle after reset",
            {30'h0, bus_req, rsp_valid}, 32'h0);
        run_all();
        lat_mode = 1;
        stat_reads = 0;
        run_all();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired before the sequence ended");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule